// File: doc/BRIEF.md
# Decode Path Selector

This block sits behind an instruction buffer that has already classified its two oldest entries. Each clock it looks at those two descriptors and commits one decoder family: the short decoders (one or two instructions), the long decoder (one instruction, at most four operations) or the vector decoder (one instruction, or an interrupt/exception entry, handing over a full group of four operations). All families see the same buffer contents, but only one of them runs per clock.

The decision is held in one output register that feeds the operation packer through a valid/ready handshake. `take_o` tells the buffer, in the same cycle, how many entries it may pop. That count is non-zero only when the output register can load a new decision. A pending interrupt or exception takes precedence over every instruction and consumes nothing.

Top module: `dps_sel`

## Requirements
- R1: While `rst_ni` is low and after its release with no valid input, `dec_vld_o` is 0 and `take_o` is 0.
- R2: A non-complex common instruction of at most 7 bytes is short class. When both slots hold such instructions and slot 1 is not escape-class, the path is dual short (`dec_path_o`=2), 2 instructions are consumed and `dec_cnt_o`=2.
- R3: A short-class instruction, escape or not, yields 2 operations when `ins_mem_i` is set and 1 otherwise. On dual short, `dec_ops_o` is the sum of both slots.
- R4: A non-complex common instruction of 8 to 11 bytes takes the long path (`dec_path_o`=3). Exactly 1 instruction is consumed, and `dec_ops_o` is `ins_lops_i`+1, so at most 4.
- R5: A non-complex uncommon instruction of at most 7 bytes takes the long path, whatever its escape flag.
- R6: A complex/serializing instruction, a common instruction longer than 11 bytes, or an uncommon instruction longer than 7 bytes takes the vector path (`dec_path_o`=4). It consumes 1 instruction and reports 4 operations.
- R7: An escape-class short instruction in slot 0 still pairs with a non-escape short instruction in slot 1 (dual short).
- R8: The path is single short (`dec_path_o`=1, 1 consumed) when slot 0 is short and slot 1 is one of these: invalid, escape-class, long class or vector class.
- R9: Only one decoder family runs per clock: when slot 0 goes long or vector, slot 1 is never consumed, even if it is short.
- R10: `int_pend_i` forces the vector path with 4 operations and 0 instructions consumed, with or without valid instructions.
- R11: While `dec_vld_o`=1 and `ready_i`=0, `take_o` is 0 and `dec_path_o`, `dec_cnt_o`, `dec_ops_o` and `dec_vld_o` hold their values.
- R12: If slot 0 is invalid and no interrupt is pending, nothing is consumed and no decision is issued, even if slot 1 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Operation packer accepts the held decision |
| int_pend_i | input | 1 | Interrupt or exception pending |
| ins_vld_i | input | 2 | Slot valid bits (bit 0 = oldest) |
| ins_len_i | input | 8 | Slot lengths in bytes, 4 bits per slot |
| ins_common_i | input | 2 | Slot is a commonly used instruction |
| ins_complex_i | input | 2 | Slot is complex or serializing |
| ins_esc_i | input | 2 | Slot is a floating-point escape instruction |
| ins_mem_i | input | 2 | Slot's short decode adds a load/store op |
| ins_lops_i | input | 4 | Long-decode op count minus one, 2 bits per slot |
| take_o | output | 2 | Entries popped from the buffer this cycle |
| dec_vld_o | output | 1 | Held decision is valid |
| dec_path_o | output | 3 | 0 none, 1 single short, 2 dual short, 3 long, 4 vector |
| dec_cnt_o | output | 2 | Instructions covered by the held decision |
| dec_ops_o | output | 3 | Operations produced by the held decision |

## Verification
The bench targets the pairing edges. An escape instruction in slot 1 must break the pair while one in slot 0 must not, and a design that mixed these up would either drop an escape into the second decoder or halve throughput on floating-point code. It walks the length limits at 7, 8, 11 and 12 bytes for common and uncommon instructions, where an off-by-one sends an instruction to the wrong family. It also stalls the packer while the inputs change, which catches a register that reloads under backpressure or pops buffer entries that were never issued. Finally it raises an interrupt over valid instructions, where a faulty design would consume an instruction it never decoded.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [2:0] {
    PATH_NONE   = 3'd0,
    PATH_SHORT1 = 3'd1,
    PATH_SHORT2 = 3'd2,
    PATH_LONG   = 3'd3,
    PATH_VECTOR = 3'd4
  } path_e;

  typedef enum logic [1:0] {
    CLS_SHORT     = 2'd0,
    CLS_SHORT_ESC = 2'd1,
    CLS_LONG      = 2'd2,
    CLS_VEC       = 2'd3
  } cls_e;
endpackage

// File: rtl/dps_slot_class.sv
module dps_slot_class
  import dps_pkg::*;
#(
  parameter int LEN_W         = 4,
  parameter int SHORT_MAX_LEN = 7,
  parameter int LONG_MAX_LEN  = 11,
  parameter int GROUP_OPS     = 4,
  parameter int OPS_W         = 3,
  parameter int LOPS_W        = 2
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic              common_i,
  input  logic              complex_i,
  input  logic              esc_i,
  input  logic              mem_i,
  input  logic [LOPS_W-1:0] lops_i,
  output cls_e              cls_o,
  output logic [OPS_W-1:0]  ops_o
);
  logic fits_short, fits_long;

  assign fits_short = 32'(len_i) <= SHORT_MAX_LEN;
  assign fits_long  = 32'(len_i) <= LONG_MAX_LEN;

  always_comb begin
    if (complex_i)                   cls_o = CLS_VEC;
    else if (common_i && fits_short) cls_o = esc_i ? CLS_SHORT_ESC : CLS_SHORT;
    else if (common_i && fits_long)  cls_o = CLS_LONG;
    else if (!common_i && fits_short) cls_o = CLS_LONG;
    else                             cls_o = CLS_VEC;
  end

  always_comb begin
    unique case (cls_o)
      CLS_SHORT, CLS_SHORT_ESC: ops_o = mem_i ? OPS_W'(2) : OPS_W'(1);
      CLS_LONG:                 ops_o = OPS_W'(lops_i) + OPS_W'(1);
      default:                  ops_o = OPS_W'(GROUP_OPS);
    endcase
  end
endmodule

// File: rtl/dps_path_arb.sv
module dps_path_arb
  import dps_pkg::*;
#(
  parameter int GROUP_OPS = 4,
  parameter int OPS_W     = 3
) (
  input  logic             int_pend_i,
  input  logic [1:0]       vld_i,
  input  cls_e             cls0_i,
  input  cls_e             cls1_i,
  input  logic [OPS_W-1:0] ops0_i,
  input  logic [OPS_W-1:0] ops1_i,
  output logic             sel_vld_o,
  output path_e            sel_path_o,
  output logic [1:0]       sel_cnt_o,
  output logic [OPS_W-1:0] sel_ops_o
);
  logic slot0_short, slot1_pairs;

  assign slot0_short = (cls0_i == CLS_SHORT) || (cls0_i == CLS_SHORT_ESC);
  // second short decoder takes no escape instruction
  assign slot1_pairs = vld_i[1] && (cls1_i == CLS_SHORT);

  always_comb begin
    sel_vld_o  = 1'b0;
    sel_path_o = PATH_NONE;
    sel_cnt_o  = 2'd0;
    sel_ops_o  = '0;
    if (int_pend_i) begin
      sel_vld_o  = 1'b1;
      sel_path_o = PATH_VECTOR;
      sel_ops_o  = OPS_W'(GROUP_OPS);
    end else if (vld_i[0]) begin
      sel_vld_o = 1'b1;
      sel_cnt_o = 2'd1;
      sel_ops_o = ops0_i;
      if (cls0_i == CLS_VEC)       sel_path_o = PATH_VECTOR;
      else if (cls0_i == CLS_LONG) sel_path_o = PATH_LONG;
      else if (slot0_short && slot1_pairs) begin
        sel_path_o = PATH_SHORT2;
        sel_cnt_o  = 2'd2;
        sel_ops_o  = ops0_i + ops1_i;
      end else                     sel_path_o = PATH_SHORT1;
    end
  end
endmodule

// File: rtl/dps_out_reg.sv
module dps_out_reg
  import dps_pkg::*;
#(
  parameter int OPS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic             sel_vld_i,
  input  path_e            sel_path_i,
  input  logic [1:0]       sel_cnt_i,
  input  logic [OPS_W-1:0] sel_ops_i,
  output logic [1:0]       take_o,
  output logic             vld_o,
  output path_e            path_o,
  output logic [1:0]       cnt_o,
  output logic [OPS_W-1:0] ops_o
);
  logic accept;

  assign accept = !vld_o || ready_i;
  assign take_o = accept ? sel_cnt_i : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      path_o <= PATH_NONE;
      cnt_o  <= 2'd0;
      ops_o  <= '0;
    end else if (accept) begin
      vld_o  <= sel_vld_i;
      path_o <= sel_path_i;
      cnt_o  <= sel_cnt_i;
      ops_o  <= sel_ops_i;
    end
  end
endmodule

// File: rtl/dps_sel.sv
module dps_sel
  import dps_pkg::*;
#(
  parameter int LEN_W         = 4,
  parameter int SHORT_MAX_LEN = 7,
  parameter int LONG_MAX_LEN  = 11,
  parameter int GROUP_OPS     = 4,
  localparam int OPS_W        = $clog2(GROUP_OPS + 1),
  localparam int LOPS_W       = $clog2(GROUP_OPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ready_i,
  input  logic                    int_pend_i,
  input  logic [NSLOT-1:0]        ins_vld_i,
  input  logic [NSLOT*LEN_W-1:0]  ins_len_i,
  input  logic [NSLOT-1:0]        ins_common_i,
  input  logic [NSLOT-1:0]        ins_complex_i,
  input  logic [NSLOT-1:0]        ins_esc_i,
  input  logic [NSLOT-1:0]        ins_mem_i,
  input  logic [NSLOT*LOPS_W-1:0] ins_lops_i,
  output logic [1:0]              take_o,
  output logic                    dec_vld_o,
  output logic [2:0]              dec_path_o,
  output logic [1:0]              dec_cnt_o,
  output logic [OPS_W-1:0]        dec_ops_o
);
  cls_e             cls   [NSLOT];
  logic [OPS_W-1:0] ops   [NSLOT];
  logic             sel_vld;
  path_e            sel_path, path_q;
  logic [1:0]       sel_cnt;
  logic [OPS_W-1:0] sel_ops;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dps_slot_class #(
      .LEN_W(LEN_W), .SHORT_MAX_LEN(SHORT_MAX_LEN), .LONG_MAX_LEN(LONG_MAX_LEN),
      .GROUP_OPS(GROUP_OPS), .OPS_W(OPS_W), .LOPS_W(LOPS_W)
    ) i_class (
      .len_i    (ins_len_i[s*LEN_W +: LEN_W]),
      .common_i (ins_common_i[s]),
      .complex_i(ins_complex_i[s]),
      .esc_i    (ins_esc_i[s]),
      .mem_i    (ins_mem_i[s]),
      .lops_i   (ins_lops_i[s*LOPS_W +: LOPS_W]),
      .cls_o    (cls[s]),
      .ops_o    (ops[s])
    );
  end

  dps_path_arb #(.GROUP_OPS(GROUP_OPS), .OPS_W(OPS_W)) i_arb (
    .int_pend_i(int_pend_i),
    .vld_i     (ins_vld_i),
    .cls0_i    (cls[0]),
    .cls1_i    (cls[1]),
    .ops0_i    (ops[0]),
    .ops1_i    (ops[1]),
    .sel_vld_o (sel_vld),
    .sel_path_o(sel_path),
    .sel_cnt_o (sel_cnt),
    .sel_ops_o (sel_ops)
  );

  dps_out_reg #(.OPS_W(OPS_W)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (ready_i),
    .sel_vld_i (sel_vld),
    .sel_path_i(sel_path),
    .sel_cnt_i (sel_cnt),
    .sel_ops_i (sel_ops),
    .take_o    (take_o),
    .vld_o     (dec_vld_o),
    .path_o    (path_q),
    .cnt_o     (dec_cnt_o),
    .ops_o     (dec_ops_o)
  );

  assign dec_path_o = path_q;
endmodule

// File: rtl/dps_chk.sv
module dps_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       int_pend_i,
  input logic [1:0] ins_vld_i,
  input logic [1:0] ins_esc_i,
  input logic [1:0] take_o,
  input logic       dec_vld_o,
  input logic [2:0] dec_path_o,
  input logic [1:0] dec_cnt_o,
  input logic [2:0] dec_ops_o
);
  // R11
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o && !ready_i |=> dec_vld_o && $stable(dec_path_o) && $stable(dec_ops_o) && $stable(dec_cnt_o));
  // R11
  no_pop_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o && !ready_i |-> take_o == 2'd0);
  // R10
  irq_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pend_i |-> take_o == 2'd0);
  // R10
  irq_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pend_i && (!dec_vld_o || ready_i) |=> dec_vld_o && dec_path_o == 3'd4 && dec_ops_o == 3'd4);
  // R9
  pop_matches_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o != 2'd0 |=> dec_vld_o && dec_cnt_o == $past(take_o));
  // R8
  pair_needs_plain_slot1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o == 2'd2 |-> ins_vld_i == 2'b11 && !ins_esc_i[1]);
  // R12
  idle_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_vld_i[0] |-> take_o == 2'd0);
  // R4
  ops_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o && dec_path_o != 3'd4 |-> dec_ops_o != 3'd0 && dec_ops_o <= 3'd4);
endmodule

bind dps_sel dps_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .int_pend_i(int_pend_i),
  .ins_vld_i (ins_vld_i),
  .ins_esc_i (ins_esc_i),
  .take_o    (take_o),
  .dec_vld_o (dec_vld_o),
  .dec_path_o(dec_path_o),
  .dec_cnt_o (dec_cnt_o),
  .dec_ops_o (dec_ops_o)
);

// File: tb/test_dps_sel.sv
module test_dps_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ready_i = 1'b1;
  logic       int_pend_i = 1'b0;
  logic [1:0] ins_vld_i = '0;
  logic [7:0] ins_len_i = '0;
  logic [1:0] ins_common_i = '0;
  logic [1:0] ins_complex_i = '0;
  logic [1:0] ins_esc_i = '0;
  logic [1:0] ins_mem_i = '0;
  logic [3:0] ins_lops_i = '0;
  logic [1:0] take_o;
  logic       dec_vld_o;
  logic [2:0] dec_path_o;
  logic [1:0] dec_cnt_o;
  logic [2:0] dec_ops_o;

  int n_chk = 0;
  int n_fail = 0;

  dps_sel i_dps_sel (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    ins_vld_i = '0; ins_len_i = '0; ins_common_i = '0; ins_complex_i = '0;
    ins_esc_i = '0; ins_mem_i = '0; ins_lops_i = '0; int_pend_i = 1'b0;
  endtask

  task automatic slot(int s, bit cm, int len, bit cx, bit esc, bit mem, int lops);
    ins_vld_i[s] = 1'b1;
    ins_common_i[s] = cm;
    ins_len_i[s*4 +: 4] = 4'(len);
    ins_complex_i[s] = cx;
    ins_esc_i[s] = esc;
    ins_mem_i[s] = mem;
    ins_lops_i[s*2 +: 2] = 2'(lops);
  endtask

  // inputs already driven; check pop now, then decision after the edge
  task automatic expect_dec(string req, int take, int vld, int path, int cnt, int ops);
    #1;
    chk(req, "take_o", int'(take_o), take);
    @(posedge clk_i); #1;
    chk(req, "dec_vld_o", int'(dec_vld_o), vld);
    chk(req, "dec_path_o", int'(dec_path_o), path);
    if (vld != 0) begin
      chk(req, "dec_cnt_o", int'(dec_cnt_o), cnt);
      chk(req, "dec_ops_o", int'(dec_ops_o), ops);
    end
    clr();
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "dec_vld_o in reset", int'(dec_vld_o), 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    expect_dec("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_dual_short();
    slot(0, 1, 3, 0, 0, 0, 0); slot(1, 1, 7, 0, 0, 1, 0);
    expect_dec("R2", 2, 1, 2, 2, 3);
    slot(0, 1, 1, 0, 0, 1, 0); slot(1, 1, 2, 0, 0, 1, 0);
    expect_dec("R3", 2, 1, 2, 2, 4);
    slot(0, 1, 0, 0, 0, 0, 0); slot(1, 1, 5, 0, 0, 0, 0);
    expect_dec("R3", 2, 1, 2, 2, 2);
  endtask

  task automatic t_escape();
    slot(0, 1, 2, 0, 1, 1, 0); slot(1, 1, 1, 0, 0, 0, 0);
    expect_dec("R7", 2, 1, 2, 2, 3);
    slot(0, 1, 2, 0, 0, 0, 0); slot(1, 1, 2, 0, 1, 1, 0);
    expect_dec("R8", 1, 1, 1, 1, 1);
    slot(0, 1, 3, 0, 1, 1, 0);
    expect_dec("R3", 1, 1, 1, 1, 2);
  endtask

  task automatic t_second_blocked();
    slot(0, 1, 4, 0, 0, 1, 0); slot(1, 1, 8, 0, 0, 0, 3);
    expect_dec("R8", 1, 1, 1, 1, 2);
    slot(0, 1, 4, 0, 0, 0, 0); slot(1, 1, 3, 1, 0, 0, 0);
    expect_dec("R8", 1, 1, 1, 1, 1);
    slot(0, 1, 4, 0, 0, 0, 0); slot(1, 0, 3, 0, 0, 0, 0);
    expect_dec("R8", 1, 1, 1, 1, 1);
  endtask

  task automatic t_long();
    slot(0, 1, 11, 0, 0, 0, 3); slot(1, 1, 2, 0, 0, 0, 0);
    expect_dec("R4 R9", 1, 1, 3, 1, 4);
    slot(0, 1, 8, 0, 0, 1, 0);
    expect_dec("R4", 1, 1, 3, 1, 1);
    slot(0, 0, 7, 0, 1, 0, 1); slot(1, 1, 2, 0, 0, 0, 0);
    expect_dec("R5 R9", 1, 1, 3, 1, 2);
  endtask

  task automatic t_vector();
    slot(0, 1, 2, 1, 0, 0, 0); slot(1, 1, 2, 0, 0, 0, 0);
    expect_dec("R6 R9", 1, 1, 4, 1, 4);
    slot(0, 1, 12, 0, 0, 0, 0);
    expect_dec("R6", 1, 1, 4, 1, 4);
    slot(0, 0, 8, 0, 0, 0, 0);
    expect_dec("R6", 1, 1, 4, 1, 4);
  endtask

  task automatic t_irq();
    int_pend_i = 1'b1;
    expect_dec("R10", 0, 1, 4, 0, 4);
    int_pend_i = 1'b1; slot(0, 1, 2, 0, 0, 0, 0); slot(1, 1, 2, 0, 0, 0, 0);
    expect_dec("R10", 0, 1, 4, 0, 4);
  endtask

  task automatic t_stall();
    slot(0, 1, 3, 0, 0, 1, 0); slot(1, 1, 3, 0, 0, 0, 0);
    expect_dec("R11", 2, 1, 2, 2, 3);
    ready_i = 1'b0;
    slot(0, 1, 9, 0, 0, 0, 2);
    #1;
    chk("R11", "take_o stalled", int'(take_o), 0);
    @(posedge clk_i); #1;
    chk("R11", "dec_path_o held", int'(dec_path_o), 2);
    chk("R11", "dec_ops_o held", int'(dec_ops_o), 3);
    chk("R11", "dec_vld_o held", int'(dec_vld_o), 1);
    ready_i = 1'b1;
    expect_dec("R11", 1, 1, 3, 1, 3);
  endtask

  task automatic t_slot1_only();
    slot(1, 1, 2, 0, 0, 0, 0);
    expect_dec("R12", 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_dual_short();
    t_escape();
    t_second_blocked();
    t_long();
    t_vector();
    t_irq();
    t_stall();
    t_slot1_only();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule